// File: doc/BRIEF.md
# Pixel Configuration Latch Matrix

This block models the configuration storage of a small pixel array. Every pixel holds two level-sensitive bits. The first is a mask bit, which suppresses the pixel's hit. The second is a pulse-enable bit, which marks the pixel for test pulsing. Neither bit has a reset.

A bit is written by crossing two selections. A column selection picks columns, and a row selection picks rows. While a crossing is active, the addressed latch follows one global data bit that is shared by every pixel.

The row selection is shared between the two latch banks through a 1-to-2 demultiplexer for each row. A single bank-select input routes the row bits onto either the mask rows or the pulse rows, and the other bank's rows stay low.

The selection inputs, the bank select and the data bit are captured in registers on the clock, and those registers then drive the select lines. The block outputs the hit vector with masked pixels forced low. For checking only, it also outputs the contents of both latch banks. These banks cannot be read back through the configuration path.

Top module: `pixcfg_matrix`

## Requirements
- R1: While `rstN` is low, all column and row select lines are held low, so no latch opens, whatever the selection inputs carry.
- R2: With `bankSelIn` = 0, the mask latch of pixel (column c, row r) takes `dataIn` when column bit c and row bit r are both set. All other mask latches keep their values.
- R3: With `bankSelIn` = 1, the same coincidence writes the pulse-enable latch instead. No mask latch changes during a pulse-bank write, and no pulse latch changes during a mask-bank write.
- R4: While no row line of a bank is active, changes on `dataIn` leave every latch of that bank unchanged.
- R5: While a crossing stays selected, the latch is transparent. It follows every change of the registered data bit, one clock after each change is presented.
- R6: `maskedHit[i]` equals `hitIn[i]` when mask bit i is 0, and is 0 when mask bit i is 1. This path is combinational.
- R7: Pixel (c, r) is bit r*NCOL + c of `hitIn`, `maskedHit`, `maskDbg` and `pulseDbg`. Column selection bit 0 is the leftmost column, and row selection bit 0 is the topmost row.
- R8: Asserting `rstN` leaves the contents of both latch banks unchanged.
- R9: Selection inputs, bank select and data take effect on the latches one rising clock edge after they are presented, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the selection registers |
| rstN | input | 1 | Asynchronous active-low reset of the selection registers only |
| colSelIn | input | NCOL | Column selection, bit 0 = leftmost column |
| rowSelIn | input | NROW | Row selection, bit 0 = topmost row |
| bankSelIn | input | 1 | 0 routes rows to the mask bank, 1 routes rows to the pulse bank |
| dataIn | input | 1 | Global data bit written into opened latches |
| hitIn | input | NCOL*NROW | Raw pixel hits |
| maskedHit | output | NCOL*NROW | Hits with masked pixels forced low |
| maskDbg | output | NCOL*NROW | Mask latch contents (debug view) |
| pulseDbg | output | NCOL*NROW | Pulse-enable latch contents (debug view) |

## Verification
The bench uses the default 8-column by 4-row array. At that size it can walk a single-pixel write through all 32 crossings of both banks, and it can sweep a one-hot hit through every pixel against a known mask. The small array also makes it cheap to keep a full reference copy of both banks. The bench then compares the whole bank vectors after every write, so a stray write to any pixel outside the crossing is caught.

// File: rtl/pixcfg_pkg.sv
package pixcfg_pkg;
  // Strobes from the select-register control to the latch datapath.
  typedef struct packed {
    logic dataBit;  // registered global data line feeding every latch
  } cfgStrobe_t;
endpackage

// File: rtl/pixcfg_ctrl.sv
module pixcfg_ctrl #(
  parameter int NCOL = 8,
  parameter int NROW = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NCOL-1:0]        colSelIn,
  input  logic [NROW-1:0]        rowSelIn,
  input  logic                   bankSelIn,
  input  logic                   dataIn,
  output logic [NCOL-1:0]        colLines,
  output logic [NROW-1:0]        maskRowLines,
  output logic [NROW-1:0]        pulseRowLines,
  output pixcfg_pkg::cfgStrobe_t strb
);
  logic [NCOL-1:0] colReg;
  logic [NROW-1:0] rowReg;
  logic            bankReg;
  logic            dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colReg  <= '0;
      rowReg  <= '0;
      bankReg <= 1'b0;
      dataReg <= 1'b0;
    end else begin
      colReg  <= colSelIn;
      rowReg  <= rowSelIn;
      bankReg <= bankSelIn;
      dataReg <= dataIn;
    end
  end

  assign colLines = colReg;

  // One 1-to-2 demultiplexer per row; the idle bank stays low.
  for (genvar r = 0; r < NROW; r++) begin : g_rowDemux
    assign maskRowLines[r]  = rowReg[r] & ~bankReg;
    assign pulseRowLines[r] = rowReg[r] &  bankReg;
  end

  always_comb begin
    strb.dataBit = dataReg;
  end
endmodule

// File: rtl/pixcfg_array.sv
module pixcfg_array #(
  parameter int NCOL = 8,
  parameter int NROW = 4
) (
  input  logic [NCOL-1:0]        colLines,
  input  logic [NROW-1:0]        maskRowLines,
  input  logic [NROW-1:0]        pulseRowLines,
  input  pixcfg_pkg::cfgStrobe_t strb,
  input  logic [NCOL*NROW-1:0]   hitIn,
  output logic [NCOL*NROW-1:0]   maskQ,
  output logic [NCOL*NROW-1:0]   pulseQ,
  output logic [NCOL*NROW-1:0]   maskedHit
);
  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      localparam int PIX = r * NCOL + c;
      logic maskOpen;
      logic pulseOpen;
      assign maskOpen  = colLines[c] & maskRowLines[r];
      assign pulseOpen = colLines[c] & pulseRowLines[r];

      // Level-sensitive storage, no reset by design.
      always_latch begin
        if (maskOpen) maskQ[PIX] <= strb.dataBit;
      end
      always_latch begin
        if (pulseOpen) pulseQ[PIX] <= strb.dataBit;
      end

      assign maskedHit[PIX] = hitIn[PIX] & ~maskQ[PIX];
    end
  end
endmodule

// File: rtl/pixcfg_matrix.sv
module pixcfg_matrix #(
  parameter int NCOL = 8,
  parameter int NROW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCOL-1:0]      colSelIn,
  input  logic [NROW-1:0]      rowSelIn,
  input  logic                 bankSelIn,
  input  logic                 dataIn,
  input  logic [NCOL*NROW-1:0] hitIn,
  output logic [NCOL*NROW-1:0] maskedHit,
  output logic [NCOL*NROW-1:0] maskDbg,
  output logic [NCOL*NROW-1:0] pulseDbg
);
  logic [NCOL-1:0]        colLines;
  logic [NROW-1:0]        maskRowLines;
  logic [NROW-1:0]        pulseRowLines;
  pixcfg_pkg::cfgStrobe_t strb;

  pixcfg_ctrl #(.NCOL(NCOL), .NROW(NROW)) i_ctrl (
    .clk(clk), .rstN(rstN), .colSelIn(colSelIn), .rowSelIn(rowSelIn),
    .bankSelIn(bankSelIn), .dataIn(dataIn), .colLines(colLines),
    .maskRowLines(maskRowLines), .pulseRowLines(pulseRowLines), .strb(strb)
  );

  pixcfg_array #(.NCOL(NCOL), .NROW(NROW)) i_array (
    .colLines(colLines), .maskRowLines(maskRowLines),
    .pulseRowLines(pulseRowLines), .strb(strb), .hitIn(hitIn),
    .maskQ(maskDbg), .pulseQ(pulseDbg), .maskedHit(maskedHit)
  );
endmodule

// File: rtl/pixcfg_matrix_chk.sv
module pixcfg_matrix_chk #(
  parameter int NCOL = 8,
  parameter int NROW = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NCOL-1:0]      colSelIn,
  input logic [NCOL-1:0]      colLines,
  input logic [NROW-1:0]      maskRowLines,
  input logic [NROW-1:0]      pulseRowLines,
  input logic [NCOL*NROW-1:0] maskedHit,
  input logic [NCOL*NROW-1:0] maskDbg,
  input logic [NCOL*NROW-1:0] pulseDbg
);
  // R9: column lines follow the input sampled one edge earlier
  a_r9_col_latency: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> colLines == $past(colSelIn));

  // R3: at most one bank has active row lines
  a_r3_bank_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !((|maskRowLines) && (|pulseRowLines)));

  // R4: idle mask rows keep the mask bank
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskRowLines) == '0 && maskRowLines == '0 && !$isunknown($past(maskDbg)))
      |-> maskDbg == $past(maskDbg));

  // R4: idle pulse rows keep the pulse bank
  a_r4_pulse_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pulseRowLines) == '0 && pulseRowLines == '0 && !$isunknown($past(pulseDbg)))
      |-> pulseDbg == $past(pulseDbg));

  // R6: a masked pixel never reports a hit
  a_r6_masked_low: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(maskDbg) |-> (maskedHit & maskDbg) == '0);
endmodule

bind pixcfg_matrix pixcfg_matrix_chk #(.NCOL(NCOL), .NROW(NROW)) i_chk (
  .clk(clk), .rstN(rstN), .colSelIn(colSelIn), .colLines(colLines),
  .maskRowLines(maskRowLines), .pulseRowLines(pulseRowLines),
  .maskedHit(maskedHit), .maskDbg(maskDbg), .pulseDbg(pulseDbg)
);

// File: tb/test_pixcfg_matrix.sv
`timescale 1ns/1ps
module test_pixcfg_matrix;
  localparam int NCOL = 8;
  localparam int NROW = 4;
  localparam int NPIX = NCOL * NROW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCOL-1:0] colSelIn = '0;
  logic [NROW-1:0] rowSelIn = '0;
  logic            bankSelIn = 1'b0;
  logic            dataIn = 1'b0;
  logic [NPIX-1:0] hitIn = '0;
  logic [NPIX-1:0] maskedHit, maskDbg, pulseDbg;
  logic [NPIX-1:0] maskRef, pulseRef;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pixcfg_matrix #(.NCOL(NCOL), .NROW(NROW)) i_pixcfg_matrix (
    .clk(clk), .rstN(rstN), .colSelIn(colSelIn), .rowSelIn(rowSelIn),
    .bankSelIn(bankSelIn), .dataIn(dataIn), .hitIn(hitIn),
    .maskedHit(maskedHit), .maskDbg(maskDbg), .pulseDbg(pulseDbg)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBanks(input string tag);
    check({tag, " mask"}, 64'(maskDbg), 64'(maskRef));
    check({tag, " pulse"}, 64'(pulseDbg), 64'(pulseRef));
  endtask

  // Reference write: pixel index is r*NCOL + c (R7)
  task automatic refWrite(input logic [NCOL-1:0] c, input logic [NROW-1:0] r,
                          input logic s, input logic d);
    for (int ri = 0; ri < NROW; ri++)
      for (int ci = 0; ci < NCOL; ci++)
        if (r[ri] && c[ci]) begin
          if (s) pulseRef[ri*NCOL+ci] = d;
          else   maskRef[ri*NCOL+ci] = d;
        end
  endtask

  task automatic applySel(input logic [NCOL-1:0] c, input logic [NROW-1:0] r,
                          input logic s, input logic d);
    @(negedge clk);
    colSelIn = c; rowSelIn = r; bankSelIn = s; dataIn = d;
    @(negedge clk);
    refWrite(c, r, s, d);
  endtask

  task automatic idle();
    applySel('0, '0, bankSelIn, dataIn);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Initialise both banks to zero (banks start unknown)
    applySel('1, '1, 1'b0, 1'b0); idle();
    applySel('1, '1, 1'b1, 1'b0); idle();
    checkBanks("R2 R3 init clear");

    // R9: no effect before the edge, effect after it
    @(negedge clk);
    colSelIn = 8'h01; rowSelIn = 4'h1; bankSelIn = 1'b0; dataIn = 1'b1;
    #1 check("R9 before edge", 64'(maskDbg), 64'(maskRef));
    @(negedge clk);
    refWrite(8'h01, 4'h1, 1'b0, 1'b1);
    check("R9 after edge", 64'(maskDbg), 64'(maskRef));
    idle();

    // R2 R7: walk a single mask write over every crossing
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        applySel(NCOL'(1) << c, NROW'(1) << r, 1'b0, 1'b1);
        checkBanks("R2 R7 mask walk");
        idle();
      end

    // R3 R7: walk pulse writes on a checkerboard, mask must stay
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        applySel(NCOL'(1) << c, NROW'(1) << r, 1'b1, 1'((r + c) % 2));
        checkBanks("R3 R7 pulse walk");
        idle();
      end

    // R2: multi-column, multi-row crossing clears a rectangle pattern
    applySel(8'hA5, 4'b0110, 1'b0, 1'b0);
    checkBanks("R2 cross pattern");
    idle();

    // R4: data toggles with no active rows
    for (int k = 0; k < 6; k++) begin
      applySel('0, '0, 1'(k % 2), 1'(k / 2 % 2));
      checkBanks("R4 hold");
    end

    // R5: transparent latch follows data while crossing held
    for (int k = 0; k < 6; k++) begin
      applySel(8'h08, 4'h4, 1'b0, 1'(k % 2));
      checkBanks("R5 transparent");
    end
    idle();

    // R6: hit masking over several patterns
    for (int p = 0; p < NPIX + 3; p++) begin
      @(negedge clk);
      if (p < NPIX) hitIn = NPIX'(1) << p;
      else if (p == NPIX) hitIn = '1;
      else if (p == NPIX + 1) hitIn = {(NPIX/2){2'b10}};
      else hitIn = {(NPIX/2){2'b01}};
      #1 check("R6 masked hit", 64'(maskedHit), 64'(hitIn & ~maskRef));
    end

    // R1 R8: reset with every crossing driven and data flipped
    @(negedge clk);
    rstN = 1'b0;
    colSelIn = '1; rowSelIn = '1; dataIn = 1'b1; bankSelIn = 1'b0;
    repeat (2) @(negedge clk);
    bankSelIn = 1'b1;
    repeat (2) @(negedge clk);
    checkBanks("R1 R8 reset no write");
    colSelIn = '0; rowSelIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkBanks("R8 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule